// File: doc/BRIEF.md
# Prescaled Free-Running Timebase Counter

This block is a shared time base for a cluster of timing units. A wide up-counter runs forever, one step per prescaled tick. It has no load, preset or software reset. Every unit that timestamps or schedules events reads it from a parallel bus. The tick comes from one of two places. The first is an internal source that is active on every system clock. The second is an external pin, which is synchronized and then edge-detected so that each rising edge gives one tick. A programmable divider sits between the chosen source and the counter.

Software reaches the block through a small register port that has one write strobe, a one-bit address and a combinational read. The control word holds the divider value, the source choice and an interrupt mask. It also holds a sticky wrap indicator. Software can poll that indicator, or route it to an interrupt line through the mask. Firmware measures an elapsed interval by reading the count twice and subtracting the two values. It uses the wrap indicator to detect the case where the counter rolled over between the two reads.

Top module: `tbase_timer`

## Requirements
- R1: The count is `CNT_W` bits wide (default 24, at least 11). After the all-ones value the next step produces zero, and counting continues. Each step changes the count by exactly +1.
- R2: The divider field is control bits [7:0]. A divider value N gives one count step per N+1 source ticks, so 0 counts on every tick and 255 counts on every 256th tick.
- R3: Control bit 8 selects the source. When it is 0 (the reset value), the internal source ticks on every clock. When it is 1, each rising edge on `ext_clk_i` gives exactly one tick after synchronization, and a pin that is held steady gives no ticks.
- R4: A write to address 1 (the count) has no effect. The count keeps stepping normally, and the control word stays unchanged.
- R5: Control bit 10 is the wrap flag. It becomes 1 on the same clock edge that takes the count from all-ones to zero, and it stays at 1 until it is cleared.
- R6: A control write with bit 10 set to 1 clears the wrap flag. A control write with bit 10 set to 0 leaves the flag unchanged.
- R7: While reset is asserted, the control word reads as zero, the count is zero and the interrupt is low.
- R8: If a wrap and a clearing write fall on the same edge, the flag ends up at 1.
- R9: A new divider value takes effect only at the end of the period in progress. The current period finishes with the old length.
- R10: Control bit 9 is the interrupt mask. `ovf_irq_o` is high exactly when both the wrap flag and the mask are 1.
- R11: A read at address 1 returns the live count, and that value equals `timebus_o` in the same cycle. A read at address 0 returns the control word in bits [10:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External tick pin, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 selects control, 1 selects count |
| reg_wdata_i | input | 11 | Write data for the control word |
| reg_rdata_o | output | CNT_W | Read data for the addressed register |
| timebus_o | output | CNT_W | Live count driven to the timing units |
| ovf_irq_o | output | 1 | Wrap interrupt |

## Verification
A fault in the divider's period counter or in its latched limit shows up on `timebus_o` as a wrong spacing between steps. This is visible within one divided period, or at the latest one period after a divider write. A corrupted count value shows up as a step that is not +1 on the next edge where the count changes. A fault in the wrap-flag logic shows up on the flag bit and on the interrupt on the edge right after the all-ones value, or on the edge of a clearing write. Every wrap-related check therefore lines up with a known count value. The bench runs the count with a narrow width so that several wraps fit in a short run.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int PRESC_W = 8;
  localparam int BIT_SRC = PRESC_W;
  localparam int BIT_IEN = PRESC_W + 1;
  localparam int BIT_OVF = PRESC_W + 2;
  localparam int CTRL_W  = PRESC_W + 3;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  typedef struct packed {
    logic               ovf_flag;
    logic               irq_en;
    logic               src_ext;
    logic [PRESC_W-1:0] presc;
  } ctrl_t;
endpackage

// File: rtl/tbase_sync_edge.sv
module tbase_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         src_tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q, lim_d;
  logic         terminal;

  assign terminal = (cnt_q == lim_q);
  assign tick_o   = src_tick_i & terminal;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (src_tick_i) begin
      if (terminal) begin
        cnt_d = '0;
        lim_d = div_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap_o = tick_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_wr;

  assign ctrl_wr = wr_i & (addr_i == ADDR_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.presc   = wdata_i[PRESC_W-1:0];
      ctrl_d.src_ext = wdata_i[BIT_SRC];
      ctrl_d.irq_en  = wdata_i[BIT_IEN];
    end
    if (wrap_i)                           ctrl_d.ovf_flag = 1'b1;
    else if (ctrl_wr && wdata_i[BIT_OVF]) ctrl_d.ovf_flag = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  timebus_o,
  output logic              ovf_irq_o
);
  localparam int PAD_W = CNT_W - CTRL_W;

  logic [1:0]       rs_q;
  logic             rst_n;
  logic             ext_rise;
  logic             src_tick;
  logic             cnt_tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  tbase_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .pin_i (ext_clk_i),
    .rise_o(ext_rise)
  );

  assign src_tick = ctrl_q.src_ext ? ext_rise : 1'b1;

  tbase_prescaler #(.W(PRESC_W)) u_presc (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .src_tick_i(src_tick),
    .div_i     (ctrl_q.presc),
    .tick_o    (cnt_tick)
  );

  tbase_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .tick_i(cnt_tick),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  tbase_regs u_regs (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .wrap_i (wrap),
    .ctrl_o (ctrl_q)
  );

  always_comb begin
    if (reg_addr_i == ADDR_CNT) reg_rdata_o = cnt;
    else                        reg_rdata_o = {{PAD_W{1'b0}}, ctrl_q};
  end

  assign timebus_o = cnt;
  assign ovf_irq_o = ctrl_q.ovf_flag & ctrl_q.irq_en;
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             flag,
  input logic             irq_en,
  input logic             wr,
  input logic             addr,
  input logic             clr_bit
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_wrap_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt == MAXV) ##1 (cnt == '0) |-> flag);

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag && !(wr && !addr && clr_bit)) |=> flag);

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr && !addr && clr_bit && cnt != MAXV) |=> !flag);

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_irq_raised_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (flag && irq_en) |-> irq);
endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n),
  .cnt    (timebus_o),
  .irq    (ovf_irq_o),
  .flag   (ctrl_q.ovf_flag),
  .irq_en (ctrl_q.irq_en),
  .wr     (reg_wr_i),
  .addr   (reg_addr_i),
  .clr_bit(reg_wdata_i[tbase_pkg::BIT_OVF])
);

// File: tb/test_tbase_timer.sv
module test_tbase_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 12;
  localparam int MAXV       = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext = 1'b0;
  logic          wr = 1'b0;
  logic          addr = 1'b0;
  logic [10:0]   wdata = '0;
  logic [CW-1:0] rdata;
  logic [CW-1:0] tbus;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_timer #(.CNT_W(CW)) i_tbase_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_clk_i  (ext),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .timebus_o  (tbus),
    .ovf_irq_o  (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(bit clr, bit ien, bit src, logic [7:0] p);
    return {clr, ien, src, p};
  endfunction

  task automatic reg_write(input logic a, input logic [10:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic read_reg(input logic a, output logic [CW-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_change();
    logic [CW-1:0] prev;
    prev = tbus;
    do @(negedge clk); while (tbus == prev);
  endtask

  task automatic measure(output int n);
    logic [CW-1:0] prev;
    wait_change();
    prev = tbus;
    n = 0;
    do begin @(negedge clk); n++; end while (tbus == prev);
    check("R1 step of +1", tbus, CW'(prev + 1));
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    logic [CW-1:0] a;
    repeat (3) @(negedge clk);
    check("R7 count in reset", tbus, 0);
    check("R7 irq in reset", irq, 0);
    read_reg(1'b0, v);
    check("R7 control in reset", v, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    a = tbus;
    @(negedge clk);
    check("R3 default internal source counts every clock", tbus, CW'(a + 1));
  endtask

  task automatic t_divide();
    int n;
    foreach (n_list[i]) begin
      reg_write(1'b0, mk(0, 0, 0, n_list[i]));
      measure(n);
      measure(n);
      check("R2 period is N+1", n, n_list[i] + 1);
    end
  endtask
  logic [7:0] n_list [3] = '{8'd0, 8'd3, 8'd17};

  task automatic t_max_divide();
    int n;
    reg_write(1'b0, mk(0, 0, 0, 8'd255));
    measure(n);
    measure(n);
    check("R2 divider 255 gives 256", n, 256);
  endtask

  task automatic t_defer();
    int n;
    int k;
    logic [CW-1:0] prev;
    reg_write(1'b0, mk(0, 0, 0, 8'd40));
    measure(n);
    wait_change();
    prev = tbus;
    k = 0;
    repeat (10) begin @(negedge clk); k++; end
    reg_write(1'b0, mk(0, 0, 0, 8'd2));
    k += 2;
    while (tbus == prev) begin @(negedge clk); k++; end
    check("R9 running period keeps old length", k, 41);
    measure(n);
    check("R9 new divider after boundary", n, 3);
  endtask

  task automatic pulse();
    ext = 1'b1;
    repeat (3) @(negedge clk);
    ext = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ext();
    logic [CW-1:0] a;
    reg_write(1'b0, mk(0, 0, 1, 8'd0));
    repeat (5) @(negedge clk);
    a = tbus;
    repeat (20) @(negedge clk);
    check("R3 steady pin gives no ticks", tbus, a);
    for (int i = 0; i < 5; i++) pulse();
    repeat (4) @(negedge clk);
    check("R3 one step per pin edge", tbus, CW'(a + 5));
    reg_write(1'b0, mk(0, 0, 1, 8'd1));
    pulse();
    repeat (4) @(negedge clk);
    a = tbus;
    for (int i = 0; i < 6; i++) pulse();
    repeat (4) @(negedge clk);
    check("R2 R3 pin edges divided by two", tbus, CW'(a + 3));
  endtask

  task automatic t_no_write();
    logic [CW-1:0] a;
    logic [CW-1:0] v;
    reg_write(1'b0, mk(0, 0, 0, 8'd0));
    @(negedge clk);
    a = tbus;
    wr = 1'b1; addr = 1'b1; wdata = '0;
    @(negedge clk);
    wr = 1'b0;
    check("R4 count write ignored", tbus, CW'(a + 1));
    read_reg(1'b0, v);
    check("R4 control unchanged", v[9:0], 10'h000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      read_reg(1'b1, v);
      check("R11 read equals bus", v, tbus);
    end
  endtask

  task automatic wait_max();
    while (tbus != CW'(MAXV)) @(negedge clk);
  endtask

  task automatic t_wrap();
    logic [CW-1:0] v;
    reg_write(1'b0, mk(1, 0, 0, 8'd0));
    wait_max();
    read_reg(1'b0, v);
    check("R5 flag clear before wrap", v[10], 0);
    @(negedge clk);
    check("R1 wrap to zero", tbus, 0);
    read_reg(1'b0, v);
    check("R5 flag set by wrap", v[10], 1);
    check("R10 irq masked", irq, 0);
    reg_write(1'b0, mk(0, 1, 0, 8'd0));
    read_reg(1'b0, v);
    check("R6 writing zero keeps flag", v[10], 1);
    check("R10 irq raised", irq, 1);
    repeat (7) @(negedge clk);
    read_reg(1'b0, v);
    check("R5 flag sticky", v[10], 1);
    reg_write(1'b0, mk(1, 1, 0, 8'd0));
    read_reg(1'b0, v);
    check("R6 write one clears flag", v[10], 0);
    check("R10 irq drops with flag", irq, 0);
    wait_max();
    wr = 1'b1; addr = 1'b0; wdata = mk(1, 1, 0, 8'd0);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    check("R8 collision count wrapped", tbus, 0);
    read_reg(1'b0, v);
    check("R8 set wins over clear", v[10], 1);
    check("R8 R10 irq kept", irq, 1);
  endtask

  initial begin
    t_reset();
    t_divide();
    t_max_divide();
    t_defer();
    t_ext();
    t_no_write();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule